// File: doc/BRIEF.md
# Routed Local Interrupt Controller

This block gathers 32 peripheral interrupt requests and delivers them to a grid of sixteen parent request lines: four lines for each of four processor cores. Every source can be set up as level-sensitive or edge-sensitive and given a polarity. Every source also has a one-byte route. The upper nibble of the route selects the parent lines and the lower nibble selects the cores. If a nibble has more than one bit set, the source is delivered to every selected target.

Software sets the block up through a word-wide register bus with byte strobes. Each enable bit is changed through two separate registers: one sets bits when a 1 is written, the other clears bits when a 1 is written. Edge-sensitive sources hold a pending latch. Software clears that latch by writing a 1 to the matching bit of the status register. Each input passes through a two-flop synchroniser before any decoding, so the block can take asynchronous request pins directly.

Top module: `lirq_router`

## Requirements
- R1: After reset every enable, polarity, edge and route bit reads 0, the status register reads 0, and every parent output is low.
- R2: Route words sit at word addresses 0 to 7. Byte lane b of word k holds the route of source 4k+b. A write changes only the lanes whose byte strobe is 1, and a read returns the stored bytes.
- R3: A write to word 0x0A sets the enable bits written as 1. A write to word 0x0B clears the enable bits written as 1. Bits written as 0 leave their enable unchanged. Word 0x09 reads the enable vector.
- R4: Writing all ones to word 0x0B disables every source in one access and leaves all route bytes unchanged.
- R5: A source whose edge bit (word 0x0D) is 0 is level-sensitive. With polarity bit (word 0x0C) at 1 it is active while the input is high; with polarity at 0 it is active while the input is low.
- R6: A source whose edge bit is 1 latches a pending bit on a rising input edge when its polarity is 1, or on a falling edge when its polarity is 0. The bit stays set after the input returns to its idle level.
- R7: Writing a 1 to a bit of the status register (word 0x10) clears that source's edge latch. Bits written as 0 have no effect.
- R8: The status register (word 0x10) reads 1 only for sources that are both active and enabled.
- R9: Output bit c*4+l (core c, line l) is high when at least one enabled, active source has route bit 4+l and route bit c both set. A source with route 0 drives no output.
- R10: An input change is not visible in status after one clock edge. It becomes visible after the second clock edge, because of the two-flop synchroniser.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| irq_in | input | 32 | Raw peripheral interrupt requests, may be asynchronous |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Word address |
| bus_be | input | 4 | Byte strobes; used only by route writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed word, combinational |
| irq_out | output | 16 | Parent request lines, bit c*4+l for core c, line l |

## Verification
Level sources are driven with both polarities while their enables are toggled. This separates the polarity decode from the enable masking. Edge sources get a single transition in each direction under each polarity. This shows that only the selected edge latches, and that a latch persists until the write-one-to-clear. The routing grid is driven with one single-target route, one route that fans out to two cores, and one zero route. Together these separate the line decode, the core decode and multi-target delivery. A source is also removed while another source stays active on the same grid. A single input step is then sampled after one and after two clock edges to pin down the synchroniser depth.

// File: rtl/rintc_pkg.sv
package rintc_pkg;
  localparam int unsigned SRC_N   = 32;
  localparam int unsigned LINE_N  = 4;
  localparam int unsigned CORE_N  = 4;
  localparam int unsigned WADDR_W = 6;
  localparam int unsigned DATA_W  = 32;

  // word addresses of the control registers
  localparam logic [WADDR_W-1:0] WA_EN_RD = 6'h09;
  localparam logic [WADDR_W-1:0] WA_EN_SET = 6'h0A;
  localparam logic [WADDR_W-1:0] WA_EN_CLR = 6'h0B;
  localparam logic [WADDR_W-1:0] WA_POL    = 6'h0C;
  localparam logic [WADDR_W-1:0] WA_EDGE   = 6'h0D;
  localparam logic [WADDR_W-1:0] WA_STAT   = 6'h10;
endpackage

// File: rtl/rintc_sync.sv
module rintc_sync #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q_cur,
  output logic [W-1:0] q_prev
);
  logic [W-1:0] meta_q, cur_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      cur_q  <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= d;
      cur_q  <= meta_q;
      prev_q <= cur_q;
    end
  end

  assign q_cur  = cur_q;
  assign q_prev = prev_q;
endmodule

// File: rtl/rintc_pend.sv
module rintc_pend #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cur,
  input  logic [W-1:0] prev,
  input  logic [W-1:0] pol,
  input  logic [W-1:0] edge_mode,
  input  logic         clr_we,
  input  logic [W-1:0] clr_vec,
  output logic [W-1:0] active,
  output logic [W-1:0] lat_o
);
  logic [W-1:0] hit, lat_q, lat_d, lvl;
  logic         lat_ce;

  always_comb begin
    hit    = (cur & ~prev & pol) | (~cur & prev & ~pol);
    lat_d  = (lat_q & ~(clr_we ? clr_vec : '0)) | hit;
    lat_ce = clr_we | (|hit);
    lvl    = ~(cur ^ pol);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      lat_q <= '0;
    else if (lat_ce) lat_q <= lat_d;
  end

  assign active = (edge_mode & lat_q) | (~edge_mode & lvl);
  assign lat_o  = lat_q;
endmodule

// File: rtl/rintc_regs.sv
module rintc_regs
  import rintc_pkg::*;
#(
  parameter int unsigned NSRC = 32,
  parameter int unsigned RBITS = 8,
  parameter int unsigned AW = 6,
  parameter int unsigned DW = 32,
  localparam int unsigned NBYTE = DW / 8,
  localparam int unsigned NRW = NSRC * RBITS / DW
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_en,
  input  logic                  bus_we,
  input  logic [AW-1:0]         bus_addr,
  input  logic [NBYTE-1:0]      bus_be,
  input  logic [DW-1:0]         bus_wdata,
  output logic [DW-1:0]         bus_rdata,
  input  logic [NSRC-1:0]       status,
  output logic [NSRC-1:0]       en_q,
  output logic [NSRC-1:0]       pol_q,
  output logic [NSRC-1:0]       edge_q,
  output logic [NSRC*RBITS-1:0] route_q,
  output logic                  stat_clr_we,
  output logic [NSRC-1:0]       stat_clr_vec
);
  logic            wr;
  logic            en_ce, pol_ce, edge_ce;
  logic [NSRC-1:0] en_d;

  assign wr = bus_en & bus_we;

  always_comb begin
    en_ce   = wr & ((bus_addr == WA_EN_SET) | (bus_addr == WA_EN_CLR));
    pol_ce  = wr & (bus_addr == WA_POL);
    edge_ce = wr & (bus_addr == WA_EDGE);
    if (bus_addr == WA_EN_SET) en_d = en_q | bus_wdata;
    else                       en_d = en_q & ~bus_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      pol_q  <= '0;
      edge_q <= '0;
    end else begin
      if (en_ce)   en_q   <= en_d;
      if (pol_ce)  pol_q  <= bus_wdata;
      if (edge_ce) edge_q <= bus_wdata;
    end
  end

  for (genvar k = 0; k < NRW; k++) begin : g_rword
    for (genvar b = 0; b < NBYTE; b++) begin : g_lane
      logic ce;
      assign ce = wr & (bus_addr == AW'(k)) & bus_be[b];
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  route_q[k*DW + b*8 +: 8] <= '0;
        else if (ce) route_q[k*DW + b*8 +: 8] <= bus_wdata[b*8 +: 8];
      end
    end
  end

  assign stat_clr_we  = wr & (bus_addr == WA_STAT);
  assign stat_clr_vec = bus_wdata;

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      WA_EN_RD: bus_rdata = en_q;
      WA_POL:   bus_rdata = pol_q;
      WA_EDGE:  bus_rdata = edge_q;
      WA_STAT:  bus_rdata = status;
      default:  bus_rdata = '0;
    endcase
    for (int k = 0; k < NRW; k++) begin
      if (bus_addr == AW'(k)) bus_rdata = route_q[k*DW +: DW];
    end
  end
endmodule

// File: rtl/rintc_xbar.sv
module rintc_xbar #(
  parameter int unsigned NSRC = 32,
  parameter int unsigned NLINE = 4,
  parameter int unsigned NCORE = 4,
  localparam int unsigned RBITS = NLINE + NCORE
) (
  input  logic [NSRC-1:0]       req,
  input  logic [NSRC*RBITS-1:0] route,
  output logic [NCORE*NLINE-1:0] out
);
  for (genvar c = 0; c < NCORE; c++) begin : g_core
    for (genvar l = 0; l < NLINE; l++) begin : g_line
      logic [NSRC-1:0] sel;
      for (genvar i = 0; i < NSRC; i++) begin : g_src
        assign sel[i] = req[i] & route[i*RBITS + NCORE + l] & route[i*RBITS + c];
      end
      assign out[c*NLINE + l] = |sel;
    end
  end
endmodule

// File: rtl/lirq_router.sv
module lirq_router
  import rintc_pkg::*;
#(
  parameter int unsigned NSRC = SRC_N,
  parameter int unsigned NLINE = LINE_N,
  parameter int unsigned NCORE = CORE_N,
  parameter int unsigned AW = WADDR_W,
  parameter int unsigned DW = DATA_W,
  localparam int unsigned RBITS = NLINE + NCORE,
  localparam int unsigned NOUT = NLINE * NCORE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   irq_in,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [AW-1:0]     bus_addr,
  input  logic [DW/8-1:0]   bus_be,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic [NOUT-1:0]   irq_out
);
  logic                   rst_a_q, rst_q_n;
  logic [NSRC-1:0]        cur, prev, active, edge_lat, status;
  logic [NSRC-1:0]        en_q, pol_q, edge_q, clr_vec;
  logic                   clr_we;
  logic [NSRC*RBITS-1:0]  route_q;

  // reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_a_q <= 1'b0;
      rst_q_n <= 1'b0;
    end else begin
      rst_a_q <= 1'b1;
      rst_q_n <= rst_a_q;
    end
  end

  rintc_sync #(.W(NSRC)) u_sync (
    .clk(clk), .rst_n(rst_q_n), .d(irq_in), .q_cur(cur), .q_prev(prev)
  );

  rintc_pend #(.W(NSRC)) u_pend (
    .clk(clk), .rst_n(rst_q_n), .cur(cur), .prev(prev), .pol(pol_q),
    .edge_mode(edge_q), .clr_we(clr_we), .clr_vec(clr_vec),
    .active(active), .lat_o(edge_lat)
  );

  assign status = active & en_q;

  rintc_regs #(.NSRC(NSRC), .RBITS(RBITS), .AW(AW), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_q_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .status(status), .en_q(en_q), .pol_q(pol_q),
    .edge_q(edge_q), .route_q(route_q), .stat_clr_we(clr_we),
    .stat_clr_vec(clr_vec)
  );

  rintc_xbar #(.NSRC(NSRC), .NLINE(NLINE), .NCORE(NCORE)) u_xbar (
    .req(status), .route(route_q), .out(irq_out)
  );
endmodule

// File: rtl/rintc_chk.sv
module rintc_chk
  import rintc_pkg::*;
#(
  parameter int unsigned NSRC = 32,
  parameter int unsigned RBITS = 8,
  parameter int unsigned AW = 6,
  parameter int unsigned DW = 32,
  parameter int unsigned NOUT = 16
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  bus_en,
  input logic                  bus_we,
  input logic [AW-1:0]         bus_addr,
  input logic [DW-1:0]         bus_wdata,
  input logic [NOUT-1:0]       irq_out,
  input logic [NSRC-1:0]       en_q,
  input logic [NSRC*RBITS-1:0] route_q,
  input logic [NSRC-1:0]       edge_lat
);
  logic wr_set, wr_clr, wr_stat;
  assign wr_set  = bus_en & bus_we & (bus_addr == WA_EN_SET);
  assign wr_clr  = bus_en & bus_we & (bus_addr == WA_EN_CLR);
  assign wr_stat = bus_en & bus_we & (bus_addr == WA_STAT);

  p_reset_clean_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (en_q == '0) && (route_q == '0) && (irq_out == '0));

  p_en_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_set |=> ((en_q & $past(bus_wdata)) == $past(bus_wdata)));

  p_en_clr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clr |=> ((en_q & $past(bus_wdata)) == '0));

  p_route_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clr |=> $stable(route_q));

  p_latch_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stat |=> ((edge_lat & $past(edge_lat)) == $past(edge_lat)));

  p_quiet_unenabled_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0) |-> (irq_out == '0));
endmodule

bind lirq_router rintc_chk #(
  .NSRC(NSRC), .RBITS(RBITS), .AW(AW), .DW(DW), .NOUT(NOUT)
) u_chk (
  .clk(clk), .rst_n(rst_q_n), .bus_en(bus_en), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .irq_out(irq_out),
  .en_q(en_q), .route_q(route_q), .edge_lat(edge_lat)
);

// File: tb/tb_lirq_router.sv
`timescale 1ns/1ps
module tb_lirq_router;
  logic        clk;
  logic        rst_n;
  logic [31:0] irq_in;
  logic        bus_en, bus_we;
  logic [5:0]  bus_addr;
  logic [3:0]  bus_be;
  logic [31:0] bus_wdata, bus_rdata;
  logic [15:0] irq_out;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;

  lirq_router dut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_en(bus_en),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_be(bus_be),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %08h expected %08h", tag, got, exp);
    end
  endtask

  task automatic bw(input logic [5:0] a, input logic [31:0] d, input logic [3:0] be = 4'hF);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d; bus_be = be;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic br(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    check("R1 irq_out", {16'h0, irq_out}, 32'h0);
    br(6'h09, d); check("R1 enable", d, 32'h0);
    br(6'h0C, d); check("R1 polarity", d, 32'h0);
    br(6'h0D, d); check("R1 edge", d, 32'h0);
    br(6'h01, d); check("R1 route", d, 32'h0);
    br(6'h10, d); check("R1 status", d, 32'h0);
  endtask

  task automatic t_route;
    logic [31:0] d;
    bw(6'h01, 32'h1122_3344);
    br(6'h01, d); check("R2 full word", d, 32'h1122_3344);
    bw(6'h01, 32'hAABB_CCDD, 4'b0010);
    br(6'h01, d); check("R2 lane strobe", d, 32'h1122_CC44);
  endtask

  task automatic t_enable;
    logic [31:0] d;
    bw(6'h0A, 32'h0000_0005);
    br(6'h09, d); check("R3 set", d, 32'h0000_0005);
    bw(6'h0A, 32'h0000_0100);
    br(6'h09, d); check("R3 set keeps others", d, 32'h0000_0105);
    bw(6'h0B, 32'h0000_0004);
    br(6'h09, d); check("R3 clear one", d, 32'h0000_0101);
  endtask

  task automatic t_clear_all;
    logic [31:0] d;
    bw(6'h0A, 32'hFFFF_FFFF);
    bw(6'h0B, 32'hFFFF_FFFF);
    br(6'h09, d); check("R4 all disabled", d, 32'h0);
    br(6'h01, d); check("R4 route intact", d, 32'h1122_CC44);
    bw(6'h01, 32'h0);
  endtask

  task automatic t_level;
    logic [31:0] d;
    bw(6'h0A, 32'h0000_0008);
    idle(3);
    br(6'h10, d); check("R8 only enabled active-low", d, 32'h0000_0008);
    bw(6'h0C, 32'hFFFF_FFFF);
    br(6'h10, d); check("R5 active-high idle", d, 32'h0);
    @(negedge clk); irq_in[3] = 1'b1;
    idle(3);
    br(6'h10, d); check("R5 active-high asserted", d, 32'h0000_0008);
    @(negedge clk); irq_in[3] = 1'b0;
    idle(3);
    br(6'h10, d); check("R5 active-high released", d, 32'h0);
    bw(6'h0B, 32'hFFFF_FFFF);
    bw(6'h0C, 32'h0);
  endtask

  task automatic t_edge;
    logic [31:0] d;
    bw(6'h0C, 32'h0000_0020);
    bw(6'h0D, 32'h0000_0020);
    bw(6'h0A, 32'h0000_0020);
    idle(2);
    @(negedge clk); irq_in[5] = 1'b1;
    idle(4);
    br(6'h10, d); check("R6 rising latched", d, 32'h0000_0020);
    @(negedge clk); irq_in[5] = 1'b0;
    idle(4);
    br(6'h10, d); check("R6 latch persists", d, 32'h0000_0020);
    bw(6'h10, 32'h0000_0020);
    br(6'h10, d); check("R7 w1c clears", d, 32'h0);
    bw(6'h0C, 32'h0);
    @(negedge clk); irq_in[5] = 1'b1;
    idle(4);
    br(6'h10, d); check("R6 rising ignored when falling", d, 32'h0);
    @(negedge clk); irq_in[5] = 1'b0;
    idle(4);
    br(6'h10, d); check("R6 falling latched", d, 32'h0000_0020);
    bw(6'h10, 32'h0000_0000);
    br(6'h10, d); check("R7 zero write no effect", d, 32'h0000_0020);
    bw(6'h10, 32'h0000_0020);
    br(6'h10, d); check("R7 w1c clears falling", d, 32'h0);
    bw(6'h0B, 32'hFFFF_FFFF);
    bw(6'h0D, 32'h0);
  endtask

  task automatic t_matrix;
    bw(6'h0C, 32'hFFFF_FFFF);
    bw(6'h02, 32'h0000_8621, 4'b0011);
    bw(6'h0A, 32'h0000_0700);
    @(negedge clk); irq_in[8] = 1'b1; irq_in[10] = 1'b1;
    idle(3);
    check("R9 single target", {16'h0, irq_out}, 32'h0000_0002);
    @(negedge clk); irq_in[9] = 1'b1;
    idle(3);
    check("R9 fan-out two cores", {16'h0, irq_out}, 32'h0000_0882);
    bw(6'h0B, 32'h0000_0100);
    check("R9 removed source", {16'h0, irq_out}, 32'h0000_0880);
    @(negedge clk); irq_in[8] = 1'b0; irq_in[9] = 1'b0; irq_in[10] = 1'b0;
    bw(6'h0B, 32'hFFFF_FFFF);
    check("R9 all off", {16'h0, irq_out}, 32'h0);
  endtask

  task automatic t_sync;
    logic [31:0] d;
    bw(6'h0A, 32'h0000_1000);
    idle(3);
    @(negedge clk); irq_in[12] = 1'b1;
    br(6'h10, d); check("R10 hidden after one edge", d, 32'h0);
    br(6'h10, d); check("R10 visible after two edges", d, 32'h0000_1000);
  endtask

  initial begin
    rst_n = 1'b0; irq_in = '0; bus_en = 1'b0; bus_we = 1'b0;
    bus_addr = '0; bus_be = '0; bus_wdata = '0;
    idle(4);
    rst_n = 1'b1;
    idle(4);
    t_reset();
    t_route();
    t_enable();
    t_clear_all();
    t_level();
    t_edge();
    t_matrix();
    t_sync();
    if (!done) begin
      done = 1;
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule